// File: doc/BRIEF.md
# Dual-Rate MAC Host Packet Multiplexer

This block puts a 10/100 Ethernet MAC and a gigabit MAC behind one host-side byte port. The host sees a single set of packet handshake signals (start, valid, end, acknowledge) and a single per-packet statistics output. A speed-mode input picks which MAC is live. The 10/100 MAC runs on its own slow clock, derived from the media interface. The gigabit MAC shares the host clock.

Each MAC has a small transmit buffer and a small receive buffer. Every buffer is the same dual-clock FIFO with Gray-coded pointers and two-flop synchronizers; for the gigabit MAC both sides run on the host clock. Receive buffers work store-and-forward: an entry becomes visible to the host only once the packet's last byte is stored, so the host receives each packet as one unbroken burst. A packet that does not fit is discarded and replaced by a one-byte error marker. The host samples the selected MAC's statistics vector at the moment the host sees the end of the packet.

Top module: `mac_host_mux`

## Requirements
- R1: After reset, rx_dv_o, stat_vld_o, fe_tx_dv_o and gi_tx_dv_o are low, and tx_ack_o is high.
- R2: speed_sel_i = 1 selects the gigabit MAC and speed_sel_i = 0 selects the 10/100 MAC. A host byte is taken on a clock where tx_dv_i and tx_ack_o are both high. Taken bytes reach the selected MAC in order, with start on the first byte and end on the last. The other MAC's transmit valid stays low.
- R3: tx_ack_o goes low once the selected MAC's transmit buffer holds 2^TX_AW (16 by default) bytes it has not yet handed out. With the MAC stalled, exactly 16 bytes are accepted.
- R4: On the MAC side of transmit, a byte leaves on a MAC clock where both the MAC valid and the MAC acknowledge are high. Valid, data and markers hold until that clock.
- R5: A packet received from the selected MAC reaches the host as rx bytes with rx_sop_o on the first byte and rx_eop_o on the last. rx_dv_o stays high without a gap from start to end. The packet is released only after its last byte is buffered.
- R6: A packet received by the MAC that is not selected is kept in its buffer. It is delivered to the host after the mode switches to that MAC.
- R7: stat_vld_o is high for exactly the cycles where rx_dv_o and rx_eop_o are both high. On those cycles stat_o carries the selected MAC's statistics vector and stat_err_o is 0 for a good packet. The 10/100 vector must be held stable from its packet's end until the next packet's end.
- R8: A received packet that needs more than 2^RX_AW - 1 (63) buffer entries is discarded whole. The host instead gets a one-byte packet with data 0x00, rx_sop_o and rx_eop_o both high, and stat_err_o = 1. Later packets are not affected.
- R9: A change of speed_sel_i while a transmit or receive packet is in flight has no effect until after that packet's end. The rest of the packet still goes to the MAC it started on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock, also the gigabit MAC clock |
| mii_clk_i | input | 1 | 10/100 MAC byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| speed_sel_i | input | 1 | 1 = gigabit MAC, 0 = 10/100 MAC |
| tx_sop_i | input | 1 | Host transmit first-byte marker |
| tx_eop_i | input | 1 | Host transmit last-byte marker |
| tx_dv_i | input | 1 | Host transmit byte valid |
| tx_data_i | input | 8 | Host transmit byte |
| tx_ack_o | output | 1 | Host transmit byte accepted when high with tx_dv_i |
| rx_sop_o | output | 1 | Host receive first-byte marker |
| rx_eop_o | output | 1 | Host receive last-byte marker |
| rx_dv_o | output | 1 | Host receive byte valid |
| rx_data_o | output | 8 | Host receive byte |
| stat_o | output | SW | Statistics vector of the packet ending now |
| stat_err_o | output | 1 | Packet was discarded on overflow |
| stat_vld_o | output | 1 | One-cycle statistics strobe |
| fe_tx_sop_o | output | 1 | 10/100 transmit first byte |
| fe_tx_eop_o | output | 1 | 10/100 transmit last byte |
| fe_tx_dv_o | output | 1 | 10/100 transmit byte valid |
| fe_tx_data_o | output | 8 | 10/100 transmit byte |
| fe_tx_ack_i | input | 1 | 10/100 MAC takes the byte |
| fe_rx_sop_i | input | 1 | 10/100 receive first byte |
| fe_rx_eop_i | input | 1 | 10/100 receive last byte |
| fe_rx_dv_i | input | 1 | 10/100 receive byte valid |
| fe_rx_data_i | input | 8 | 10/100 receive byte |
| fe_stat_i | input | SW | 10/100 statistics vector |
| gi_tx_sop_o | output | 1 | Gigabit transmit first byte |
| gi_tx_eop_o | output | 1 | Gigabit transmit last byte |
| gi_tx_dv_o | output | 1 | Gigabit transmit byte valid |
| gi_tx_data_o | output | 8 | Gigabit transmit byte |
| gi_tx_ack_i | input | 1 | Gigabit MAC takes the byte |
| gi_rx_sop_i | input | 1 | Gigabit receive first byte |
| gi_rx_eop_i | input | 1 | Gigabit receive last byte |
| gi_rx_dv_i | input | 1 | Gigabit receive byte valid |
| gi_rx_data_i | input | 8 | Gigabit receive byte |
| gi_stat_i | input | SW | Gigabit statistics vector |

## Verification
The bench sends packets of 1 to 70 bytes through each MAC in both directions and predicts every byte and marker from a simple formula.

It fills the transmit buffer against a stalled MAC. A full-flag that is off by one would accept 15 or 17 bytes instead of 16. It drives a 70-byte receive packet. A design without the commit pointer would release the packet's first 63 bytes with no end marker, and one without a drop path would stall. It flips the speed mode halfway through a transmit packet; the wrong design splits that packet across both MACs. It leaves a packet waiting in the unselected receive buffer; the wrong design loses it. It also checks on every cycle that no gap opens inside a received packet and that the statistics strobe stays aligned with the end byte.

// File: rtl/mhm_pkg.sv
`timescale 1ns/1ps
package mhm_pkg;
  typedef struct packed {
    logic       err;
    logic       eop;
    logic       sop;
    logic [7:0] data;
  } ent_t;
endpackage

// File: rtl/mhm_sync.sv
`timescale 1ns/1ps
module mhm_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/mhm_cdc_fifo.sv
`timescale 1ns/1ps
module mhm_cdc_fifo
  import mhm_pkg::*;
#(
  parameter int AW        = 4,
  parameter int STORE_FWD = 0
) (
  input  logic wclk_i,
  input  logic rclk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  ent_t wr_ent_i,
  output logic wr_ready_o,
  input  logic rd_en_i,
  output logic rd_valid_o,
  output ent_t rd_ent_o
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  // store-forward keeps one slot free for an error marker
  localparam int LIMIT = (STORE_FWD != 0) ? DEPTH - 1 : DEPTH;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return (b >> 1) ^ b;
  endfunction
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int k = PW - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  ent_t mem [DEPTH];
  logic [PW-1:0] wptr_q, cptr_q, wptr_n, cptr_n, cgray_q, rq_gray, rq_bin, used;
  logic [PW-1:0] rptr_q, rptr_n, rgray_q, cq_gray, cq_bin;
  logic          drop_q, drop_n, we;
  logic [AW-1:0] waddr;
  ent_t          wdata;

  // write side
  assign rq_bin     = g2b(rq_gray);
  assign used       = wptr_q - rq_bin;
  assign wr_ready_o = used < PW'(LIMIT);

  always_comb begin
    we     = 1'b0;
    waddr  = wptr_q[AW-1:0];
    wdata  = wr_ent_i;
    wptr_n = wptr_q;
    cptr_n = cptr_q;
    drop_n = drop_q;
    if (wr_en_i) begin
      if (STORE_FWD == 0) begin
        if (wr_ready_o) begin
          we     = 1'b1;
          wptr_n = wptr_q + 1'b1;
        end
      end else if (!drop_q && wr_ready_o) begin
        we     = 1'b1;
        wptr_n = wptr_q + 1'b1;
        if (wr_ent_i.eop) cptr_n = wptr_n;
      end else if (wr_ent_i.eop) begin
        we     = 1'b1;
        waddr  = cptr_q[AW-1:0];
        wdata  = ent_t'{err: 1'b1, eop: 1'b1, sop: 1'b1, data: 8'h00};
        wptr_n = cptr_q + 1'b1;
        cptr_n = wptr_n;
        drop_n = 1'b0;
      end else begin
        wptr_n = cptr_q;  // rewind the partial packet
        drop_n = 1'b1;
      end
    end
    if (STORE_FWD == 0) cptr_n = wptr_n;
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      cptr_q  <= '0;
      cgray_q <= '0;
      drop_q  <= 1'b0;
    end else begin
      wptr_q  <= wptr_n;
      cptr_q  <= cptr_n;
      cgray_q <= b2g(cptr_n);
      drop_q  <= drop_n;
    end
  end

  always_ff @(posedge wclk_i) begin
    if (we) mem[waddr] <= wdata;
  end

  // read side
  assign cq_bin     = g2b(cq_gray);
  assign rd_valid_o = rptr_q != cq_bin;
  assign rd_ent_o   = mem[rptr_q[AW-1:0]];
  assign rptr_n     = rptr_q + {{(PW-1){1'b0}}, rd_en_i & rd_valid_o};

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      rgray_q <= '0;
    end else begin
      rptr_q  <= rptr_n;
      rgray_q <= b2g(rptr_n);
    end
  end

  mhm_sync #(.W(PW)) u_c2r (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(cgray_q), .q_o(cq_gray));
  mhm_sync #(.W(PW)) u_r2w (.clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray_q), .q_o(rq_gray));

  a_r3_used_bound: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    used <= PW'(DEPTH));
  a_r4_rd_when_valid: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_valid_o) |=> $stable(rptr_q));
  // R5: a released packet is fully buffered
  a_r5_sf_contig: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ((STORE_FWD != 0) && rd_en_i && rd_valid_o && !rd_ent_o.eop) |=> rd_valid_o);
endmodule

// File: rtl/mac_host_mux.sv
`timescale 1ns/1ps
module mac_host_mux
  import mhm_pkg::*;
#(
  parameter int SW    = 16,
  parameter int TX_AW = 4,
  parameter int RX_AW = 6
) (
  input  logic          clk_i,
  input  logic          mii_clk_i,
  input  logic          rst_ni,
  input  logic          speed_sel_i,
  input  logic          tx_sop_i,
  input  logic          tx_eop_i,
  input  logic          tx_dv_i,
  input  logic [7:0]    tx_data_i,
  output logic          tx_ack_o,
  output logic          rx_sop_o,
  output logic          rx_eop_o,
  output logic          rx_dv_o,
  output logic [7:0]    rx_data_o,
  output logic [SW-1:0] stat_o,
  output logic          stat_err_o,
  output logic          stat_vld_o,
  output logic          fe_tx_sop_o,
  output logic          fe_tx_eop_o,
  output logic          fe_tx_dv_o,
  output logic [7:0]    fe_tx_data_o,
  input  logic          fe_tx_ack_i,
  input  logic          fe_rx_sop_i,
  input  logic          fe_rx_eop_i,
  input  logic          fe_rx_dv_i,
  input  logic [7:0]    fe_rx_data_i,
  input  logic [SW-1:0] fe_stat_i,
  output logic          gi_tx_sop_o,
  output logic          gi_tx_eop_o,
  output logic          gi_tx_dv_o,
  output logic [7:0]    gi_tx_data_o,
  input  logic          gi_tx_ack_i,
  input  logic          gi_rx_sop_i,
  input  logic          gi_rx_eop_i,
  input  logic          gi_rx_dv_i,
  input  logic [7:0]    gi_rx_data_i,
  input  logic [SW-1:0] gi_stat_i
);
  localparam int NMAC = 2;  // index 0: 10/100, index 1: gigabit

  logic [NMAC-1:0] mac_clk, mac_tx_ack, mac_rx_dv;
  logic [NMAC-1:0] tx_ready, tx_valid, tx_wr_en, rx_valid, rx_rd, rx_space;
  ent_t            tx_ent;
  ent_t            tx_head [NMAC];
  ent_t            rx_head [NMAC];
  ent_t            mac_rx_ent [NMAC];
  logic [SW-1:0]   stat_raw [NMAC];
  logic [SW-1:0]   stat_in  [NMAC];

  assign mac_clk       = {clk_i, mii_clk_i};
  assign mac_tx_ack    = {gi_tx_ack_i, fe_tx_ack_i};
  assign mac_rx_dv     = {gi_rx_dv_i, fe_rx_dv_i};
  assign mac_rx_ent[0] = ent_t'{err: 1'b0, eop: fe_rx_eop_i, sop: fe_rx_sop_i, data: fe_rx_data_i};
  assign mac_rx_ent[1] = ent_t'{err: 1'b0, eop: gi_rx_eop_i, sop: gi_rx_sop_i, data: gi_rx_data_i};
  assign stat_raw[0]   = fe_stat_i;
  assign stat_raw[1]   = gi_stat_i;
  assign tx_ent        = ent_t'{err: 1'b0, eop: tx_eop_i, sop: tx_sop_i, data: tx_data_i};

  for (genvar i = 0; i < NMAC; i++) begin : g_mac
    mhm_cdc_fifo #(.AW(TX_AW), .STORE_FWD(0)) u_txf (
      .wclk_i(clk_i), .rclk_i(mac_clk[i]), .rst_ni(rst_ni),
      .wr_en_i(tx_wr_en[i]), .wr_ent_i(tx_ent), .wr_ready_o(tx_ready[i]),
      .rd_en_i(mac_tx_ack[i]), .rd_valid_o(tx_valid[i]), .rd_ent_o(tx_head[i]));
    mhm_cdc_fifo #(.AW(RX_AW), .STORE_FWD(1)) u_rxf (
      .wclk_i(mac_clk[i]), .rclk_i(clk_i), .rst_ni(rst_ni),
      .wr_en_i(mac_rx_dv[i]), .wr_ent_i(mac_rx_ent[i]), .wr_ready_o(rx_space[i]),
      .rd_en_i(rx_rd[i]), .rd_valid_o(rx_valid[i]), .rd_ent_o(rx_head[i]));
    if (i == 0) begin : g_slow_stat
      // vector is held stable by the slow MAC, so a plain bus synchronizer suffices
      mhm_sync #(.W(SW)) u_ssync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(stat_raw[i]), .q_o(stat_in[i]));
    end else begin : g_fast_stat
      assign stat_in[i] = stat_raw[i];
    end
  end

  assign fe_tx_dv_o   = tx_valid[0];
  assign fe_tx_sop_o  = tx_head[0].sop;
  assign fe_tx_eop_o  = tx_head[0].eop;
  assign fe_tx_data_o = tx_head[0].data;
  assign gi_tx_dv_o   = tx_valid[1];
  assign gi_tx_sop_o  = tx_head[1].sop;
  assign gi_tx_eop_o  = tx_head[1].eop;
  assign gi_tx_data_o = tx_head[1].data;

  // host side steering
  logic act_q, tx_busy_q, rx_busy_q, tx_fire, rx_fire, idle;
  ent_t head;

  assign tx_ack_o = tx_ready[act_q];
  assign tx_fire  = tx_dv_i & tx_ack_o;
  assign rx_fire  = rx_valid[act_q];
  assign head     = rx_head[act_q];
  assign idle     = !tx_busy_q && !rx_busy_q && !tx_fire && !rx_fire;

  always_comb begin
    tx_wr_en        = '0;
    tx_wr_en[act_q] = tx_fire;
    rx_rd           = '0;
    rx_rd[act_q]    = rx_fire;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      tx_busy_q  <= 1'b0;
      rx_busy_q  <= 1'b0;
      rx_dv_o    <= 1'b0;
      rx_sop_o   <= 1'b0;
      rx_eop_o   <= 1'b0;
      rx_data_o  <= '0;
      stat_vld_o <= 1'b0;
      stat_err_o <= 1'b0;
      stat_o     <= '0;
    end else begin
      if (idle) act_q <= speed_sel_i;
      if (tx_fire) tx_busy_q <= !tx_eop_i;
      if (rx_fire) rx_busy_q <= !head.eop;
      rx_dv_o    <= rx_fire;
      rx_sop_o   <= rx_fire & head.sop;
      rx_eop_o   <= rx_fire & head.eop;
      rx_data_o  <= rx_fire ? head.data : 8'h00;
      stat_vld_o <= rx_fire & head.eop;
      if (rx_fire && head.eop) begin
        stat_o     <= stat_in[act_q];
        stat_err_o <= head.err;
      end
    end
  end

  a_r5_rx_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_dv_o && !rx_eop_o) |=> rx_dv_o);
  a_r9_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy_q || rx_busy_q) |=> $stable(act_q));
  a_r5_sop_with_dv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_sop_o |-> rx_dv_o);
  a_r2_one_tx_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_wr_en));
endmodule

// File: tb/mac_host_mux_tb.sv
`timescale 1ns/1ps
module mac_host_mux_tb;
  localparam int SW = 16;

  logic clk = 0, mii_clk = 0, rst_n = 0;
  always #10 clk = ~clk;
  always #50 mii_clk = ~mii_clk;

  logic          speed_sel = 1'b1;
  logic          tx_sop = 0, tx_eop = 0, tx_dv = 0;
  logic [7:0]    tx_data = 0;
  logic          tx_ack;
  logic          rx_sop, rx_eop, rx_dv, stat_err, stat_vld;
  logic [7:0]    rx_data;
  logic [SW-1:0] stat;
  logic          fe_tx_sop, fe_tx_eop, fe_tx_dv, fe_tx_ack = 0;
  logic [7:0]    fe_tx_data;
  logic          fe_rx_sop = 0, fe_rx_eop = 0, fe_rx_dv = 0;
  logic [7:0]    fe_rx_data = 0;
  logic [SW-1:0] fe_stat = 0, gi_stat = 0;
  logic          gi_tx_sop, gi_tx_eop, gi_tx_dv, gi_tx_ack = 1;
  logic [7:0]    gi_tx_data;
  logic          gi_rx_sop = 0, gi_rx_eop = 0, gi_rx_dv = 0;
  logic [7:0]    gi_rx_data = 0;

  mac_host_mux u_dut (
    .clk_i(clk), .mii_clk_i(mii_clk), .rst_ni(rst_n), .speed_sel_i(speed_sel),
    .tx_sop_i(tx_sop), .tx_eop_i(tx_eop), .tx_dv_i(tx_dv), .tx_data_i(tx_data), .tx_ack_o(tx_ack),
    .rx_sop_o(rx_sop), .rx_eop_o(rx_eop), .rx_dv_o(rx_dv), .rx_data_o(rx_data),
    .stat_o(stat), .stat_err_o(stat_err), .stat_vld_o(stat_vld),
    .fe_tx_sop_o(fe_tx_sop), .fe_tx_eop_o(fe_tx_eop), .fe_tx_dv_o(fe_tx_dv),
    .fe_tx_data_o(fe_tx_data), .fe_tx_ack_i(fe_tx_ack),
    .fe_rx_sop_i(fe_rx_sop), .fe_rx_eop_i(fe_rx_eop), .fe_rx_dv_i(fe_rx_dv),
    .fe_rx_data_i(fe_rx_data), .fe_stat_i(fe_stat),
    .gi_tx_sop_o(gi_tx_sop), .gi_tx_eop_o(gi_tx_eop), .gi_tx_dv_o(gi_tx_dv),
    .gi_tx_data_o(gi_tx_data), .gi_tx_ack_i(gi_tx_ack),
    .gi_rx_sop_i(gi_rx_sop), .gi_rx_eop_i(gi_rx_eop), .gi_rx_dv_i(gi_rx_dv),
    .gi_rx_data_i(gi_rx_data), .gi_stat_i(gi_stat));

  int total = 0, bad = 0, cyc = 0;
  logic [9:0]  fq [0:511];
  logic [9:0]  gq [0:511];
  logic [9:0]  rq [0:511];
  logic [16:0] sq [0:63];
  int fn = 0, gn = 0, rn = 0, sn = 0, acc = 0, fe_ph = 0;
  logic fe_ack_en = 1, in_pkt = 0, gap_err = 0, vld_err = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // gigabit MAC transmit sink, always ready
  always @(negedge clk) if (gi_tx_dv && gi_tx_ack) begin gq[gn] = {gi_tx_sop, gi_tx_eop, gi_tx_data}; gn++; end
  // 10/100 MAC transmit sink, ack two of every three clocks
  always @(negedge mii_clk) begin
    fe_tx_ack = fe_ack_en && (fe_ph % 3 != 2);
    fe_ph++;
    if (fe_tx_dv && fe_tx_ack) begin fq[fn] = {fe_tx_sop, fe_tx_eop, fe_tx_data}; fn++; end
  end
  // host receive monitor
  always @(negedge clk) begin
    if (tx_dv && tx_ack) acc++;
    if (stat_vld != (rx_dv && rx_eop)) vld_err = 1;
    if (in_pkt && !rx_dv) gap_err = 1;
    if (rx_dv) begin
      rq[rn] = {rx_sop, rx_eop, rx_data}; rn++;
      in_pkt = !rx_eop;
    end
    if (stat_vld) begin sq[sn] = {stat_err, stat}; sn++; end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic host_send(input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      tx_dv = 1; tx_sop = (k == 0); tx_eop = (k == n - 1); tx_data = 8'(seed + k * 7);
      while (!tx_ack) @(negedge clk);
      @(negedge clk);
    end
    tx_dv = 0; tx_sop = 0; tx_eop = 0;
  endtask

  task automatic gi_rx_send(input int n, input int seed, input logic [SW-1:0] sv);
    gi_stat = sv;
    for (int k = 0; k < n; k++) begin
      gi_rx_dv = 1; gi_rx_sop = (k == 0); gi_rx_eop = (k == n - 1); gi_rx_data = 8'(seed + k * 7);
      @(negedge clk);
    end
    gi_rx_dv = 0; gi_rx_sop = 0; gi_rx_eop = 0;
  endtask

  task automatic fe_rx_send(input int n, input int seed, input logic [SW-1:0] sv);
    @(negedge mii_clk);
    fe_stat = sv;
    for (int k = 0; k < n; k++) begin
      fe_rx_dv = 1; fe_rx_sop = (k == 0); fe_rx_eop = (k == n - 1); fe_rx_data = 8'(seed + k * 7);
      @(negedge mii_clk);
    end
    fe_rx_dv = 0; fe_rx_sop = 0; fe_rx_eop = 0;
  endtask

  // which: 0 = 10/100 tx sink, 1 = gigabit tx sink, 2 = host rx
  task automatic chk_pkt(input int which, input int base, input int n, input int seed, input string tag);
    int bk = -1;
    logic [9:0] got = 0, ex = 0;
    for (int k = 0; k < n; k++) begin
      logic [9:0] g, e;
      g = (which == 0) ? fq[base+k] : (which == 1) ? gq[base+k] : rq[base+k];
      e = {k == 0, k == n - 1, 8'(seed + k * 7)};
      if (g !== e && bk < 0) begin bk = k; got = g; ex = e; end
    end
    chk(bk < 0, tag, int'(got), int'(ex));
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int b, s;
    wait_clk(3);
    rst_n = 1;
    wait_clk(2);
    chk({rx_dv, stat_vld, fe_tx_dv, gi_tx_dv, tx_ack} == 5'b00001, "R1 reset state",
        int'({rx_dv, stat_vld, fe_tx_dv, gi_tx_dv, tx_ack}), 1);
    wait_clk(6);

    // gigabit transmit, several lengths
    b = gn;
    host_send(1, 8'h10); host_send(3, 8'h20); host_send(17, 8'h30);
    wait_clk(20);
    chk(gn - b == 21, "R2 gig tx byte count", gn - b, 21);
    chk_pkt(1, b, 1, 8'h10, "R2 gig tx 1-byte");
    chk_pkt(1, b + 1, 3, 8'h20, "R2 gig tx 3-byte");
    chk_pkt(1, b + 4, 17, 8'h30, "R4 gig tx 17-byte");
    chk(fn == 0, "R2 unselected 10/100 tx idle", fn, 0);

    // gigabit receive
    b = rn; s = sn;
    gi_rx_send(4, 8'h40, 16'hA004); wait_clk(20);
    gi_rx_send(9, 8'h50, 16'hA009); wait_clk(30);
    chk(rn - b == 13, "R5 gig rx byte count", rn - b, 13);
    chk_pkt(2, b, 4, 8'h40, "R5 gig rx 4-byte");
    chk_pkt(2, b + 4, 9, 8'h50, "R5 gig rx 9-byte");
    chk(sn - s == 2 && sq[s] == {1'b0, 16'hA004} && sq[s+1] == {1'b0, 16'hA009},
        "R7 gig stats", int'(sq[s+1]), 32'hA009);

    // switch to 10/100
    speed_sel = 0; wait_clk(10);
    b = fn; s = gn;
    host_send(2, 8'h60); host_send(20, 8'h70);
    wait_clk(600);
    chk(fn - b == 22, "R2 fe tx byte count", fn - b, 22);
    chk_pkt(0, b, 2, 8'h60, "R4 fe tx 2-byte");
    chk_pkt(0, b + 2, 20, 8'h70, "R4 fe tx 20-byte");
    chk(gn == s, "R2 unselected gig tx idle", gn, s);

    b = rn; s = sn;
    fe_rx_send(5, 8'h80, 16'hB005); wait_clk(60);
    fe_rx_send(12, 8'h90, 16'hB00C); wait_clk(60);
    chk(rn - b == 17, "R5 fe rx byte count", rn - b, 17);
    chk_pkt(2, b, 5, 8'h80, "R5 fe rx 5-byte");
    chk_pkt(2, b + 5, 12, 8'h90, "R5 fe rx 12-byte");
    chk(sn - s == 2 && sq[s] == {1'b0, 16'hB005} && sq[s+1] == {1'b0, 16'hB00C},
        "R7 fe stats", int'(sq[s+1]), 32'hB00C);

    // overflow: 70-byte packet dropped, then a normal one
    b = rn; s = sn;
    fe_rx_send(70, 8'h01, 16'hB046); wait_clk(60);
    chk(rn - b == 1 && rq[b] == {1'b1, 1'b1, 8'h00}, "R8 overflow marker",
        int'(rq[b]), 32'h300);
    chk(sn - s == 1 && sq[s][16] == 1'b1, "R8 overflow error flag", int'(sq[s][16]), 1);
    fe_rx_send(3, 8'hC0, 16'hB003); wait_clk(60);
    chk_pkt(2, b + 1, 3, 8'hC0, "R8 packet after overflow");
    chk(sq[s+1] == {1'b0, 16'hB003}, "R8 stats after overflow", int'(sq[s+1]), 32'hB003);

    // transmit buffer full against a stalled MAC
    fe_ack_en = 0; wait_clk(20);
    b = fn; acc = 0;
    fork
      host_send(20, 8'hD0);
      begin
        wait_clk(60);
        chk(acc == 16, "R3 bytes accepted while stalled", acc, 16);
        chk(tx_ack == 1'b0, "R3 ack low when full", int'(tx_ack), 0);
        fe_ack_en = 1;
      end
    join
    wait_clk(600);
    chk_pkt(0, b, 20, 8'hD0, "R3 packet after stall");

    // mode change in the middle of a transmit packet
    b = fn; s = gn;
    fork
      host_send(10, 8'hE0);
      begin wait_clk(3); speed_sel = 1; end
    join
    wait_clk(500);
    chk(fn - b == 10 && gn == s, "R9 packet stays on 10/100", fn - b, 10);
    chk_pkt(0, b, 10, 8'hE0, "R9 packet content");
    s = gn;
    host_send(4, 8'hF0); wait_clk(20);
    chk(gn - s == 4, "R9 new mode after eop", gn - s, 4);
    chk_pkt(1, s, 4, 8'hF0, "R9 next packet on gig");

    // unselected receive buffer retains its packet
    b = rn;
    fe_rx_send(6, 8'h33, 16'hB006); wait_clk(80);
    chk(rn == b, "R6 held while unselected", rn - b, 0);
    speed_sel = 0; wait_clk(40);
    chk(rn - b == 6, "R6 delivered after switch", rn - b, 6);
    chk_pkt(2, b, 6, 8'h33, "R6 content");

    chk(!gap_err, "R5 no gap inside packet", int'(gap_err), 0);
    chk(!vld_err, "R7 strobe aligned to eop", int'(vld_err), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule